// File: doc/BRIEF.md
# Saturating Up/Down Counter Field

This block is a counter held in a register field that software can read and hardware can advance. A client logic path raises an increment request with a step amount, a decrement request with a step amount, or both in the same cycle. The block works out a next value from the stored count, commits it on the clock edge, and marks that edge with a one-cycle update flag. Bus access, software reload and overflow interrupts belong to the surrounding register file and are not part of the block.

Two limits, an upper ceiling and a lower floor, are fixed by parameters. When saturation is on, each step is tested on its own. A step that would take the running value above the ceiling or below the floor is dropped, and the running value is left as it was. When saturation is off, the count wraps modulo 2^WIDTH. The increment is always handled first, and the decrement is then tested against the value the increment left behind.

Top module: `satcnt_field`

## Requirements
- R1: A synchronous active-high `rst` sets `count_o` to 0 and `upd_o` to 0 at the next clock edge, whatever the request inputs are.
- R2: In a cycle with neither request high, `count_o` keeps its value and `upd_o` reads 0 after the next edge.
- R3: An increment that is allowed adds `inc_step_i` to the count. The new value appears on `count_o` after the next edge, together with `upd_o` = 1.
- R4: A decrement that is allowed subtracts `dec_step_i` from the count, with the same timing as R3.
- R5: When both requests are high, the increment is evaluated first. The decrement is then evaluated and applied on the value left after the increment. Example: count 3, increment by 4, decrement by 5, with floor 2, gives 2.
- R6: With saturation on, an increment is applied only if count + step, computed one bit wider than the count, is no greater than HI_LIMIT. A sum equal to HI_LIMIT is accepted. A sum that would overflow WIDTH bits is rejected and does not wrap.
- R7: With saturation on, a decrement is applied only if the difference has no borrow and is no less than LO_LIMIT. A result equal to LO_LIMIT is accepted.
- R8: `upd_o` is 1 for exactly the cycle after an edge at which at least one step was applied. It is 0 when every request in the cycle was rejected, and in that case `count_o` is unchanged.
- R9: A request with a step of zero that passes its limit check counts as an applied step: `upd_o` goes to 1 and the count is unchanged.
- R10: With SAT_EN = 0, both steps are always applied and the count wraps modulo 2^WIDTH. Example for WIDTH 8: 250 + 10 gives 4, and 4 − 6 gives 254.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inc_req_i | input | 1 | Increment request |
| inc_step_i | input | WIDTH | Increment amount |
| dec_req_i | input | 1 | Decrement request |
| dec_step_i | input | WIDTH | Decrement amount |
| count_o | output | WIDTH | Stored count |
| upd_o | output | 1 | One-cycle flag marking a committed update |

## Verification
The stored count is the block's only state, and it drives `count_o` directly. A wrong next-state result therefore shows up on the port one edge after the request that caused it. A check made one cycle after each request catches it at once. Faults in limit checking or in the order of the two steps leave no trace until a step lands near a limit, so the vectors place the count on HI_LIMIT, on LO_LIMIT, and just past each of them. A flag that is registered one cycle late or one cycle early makes `upd_o` disagree with the change in `count_o` in the same sampled cycle.

// File: rtl/satcnt_pkg.sv
package satcnt_pkg;

    typedef enum logic {
        STEP_UP   = 1'b0,
        STEP_DOWN = 1'b1
    } step_dir_e;

    // Widest limit comparison supported; WIDTH must stay below this.
    localparam int CMP_W = 64;

    // Decide whether a widened result is within the limit for its direction.
    function automatic logic step_allowed(
        input step_dir_e        dir,
        input logic [CMP_W-1:0] wide_val,
        input logic             borrow,
        input logic [CMP_W-1:0] limit
    );
        if (dir == STEP_UP) begin
            return wide_val <= limit;
        end
        return !borrow && (wide_val >= limit);
    endfunction

endpackage

// File: rtl/satcnt_stage.sv
module satcnt_stage
    import satcnt_pkg::*;
#(
    parameter int          W      = 8,
    parameter step_dir_e   DIR    = STEP_UP,
    parameter bit          SAT_EN = 1'b1,
    parameter int unsigned LIMIT  = 0
) (
    input  logic [W-1:0] run_i,
    input  logic         req_i,
    input  logic [W-1:0] step_i,
    output logic [W-1:0] run_o,
    output logic         hit_o
);

    localparam int XW = W + 1;

    logic [XW-1:0] wide;
    logic          allow;

    generate
        if (DIR == STEP_UP) begin : g_add
            assign wide = {1'b0, run_i} + {1'b0, step_i};
        end else begin : g_sub
            assign wide = {1'b0, run_i} - {1'b0, step_i};
        end
    endgenerate

    generate
        if (SAT_EN) begin : g_sat
            logic borrow;
            assign borrow = (DIR == STEP_DOWN) && wide[W];
            assign allow  = step_allowed(DIR, CMP_W'(wide), borrow, CMP_W'(LIMIT));
        end else begin : g_wrap
            assign allow = 1'b1;
        end
    endgenerate

    assign hit_o = req_i & allow;
    assign run_o = hit_o ? wide[W-1:0] : run_i;

endmodule

// File: rtl/satcnt_next.sv
module satcnt_next
    import satcnt_pkg::*;
#(
    parameter int          W        = 8,
    parameter bit          SAT_EN   = 1'b1,
    parameter int unsigned HI_LIMIT = 250,
    parameter int unsigned LO_LIMIT = 2
) (
    input  logic [W-1:0] cur_i,
    input  logic         inc_req_i,
    input  logic [W-1:0] inc_step_i,
    input  logic         dec_req_i,
    input  logic [W-1:0] dec_step_i,
    output logic [W-1:0] nxt_o,
    output logic         upd_o
);

    logic [W-1:0] after_inc;
    logic         inc_hit;
    logic         dec_hit;

    // Increment first, on the stored value.
    satcnt_stage #(
        .W      (W),
        .DIR    (STEP_UP),
        .SAT_EN (SAT_EN),
        .LIMIT  (HI_LIMIT)
    ) u_inc (
        .run_i  (cur_i),
        .req_i  (inc_req_i),
        .step_i (inc_step_i),
        .run_o  (after_inc),
        .hit_o  (inc_hit)
    );

    // Decrement second, on whatever the increment left.
    satcnt_stage #(
        .W      (W),
        .DIR    (STEP_DOWN),
        .SAT_EN (SAT_EN),
        .LIMIT  (LO_LIMIT)
    ) u_dec (
        .run_i  (after_inc),
        .req_i  (dec_req_i),
        .step_i (dec_step_i),
        .run_o  (nxt_o),
        .hit_o  (dec_hit)
    );

    assign upd_o = inc_hit | dec_hit;

endmodule

// File: rtl/satcnt_reg.sv
module satcnt_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic         flag_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o    <= '0;
            flag_o <= 1'b0;
        end else begin
            flag_o <= load_i;
            if (load_i) begin
                q_o <= d_i;
            end
        end
    end

endmodule

// File: rtl/satcnt_field.sv
module satcnt_field #(
    parameter int          WIDTH    = 8,
    parameter bit          SAT_EN   = 1'b1,
    parameter int unsigned HI_LIMIT = 250,
    parameter int unsigned LO_LIMIT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_req_i,
    input  logic [WIDTH-1:0] inc_step_i,
    input  logic             dec_req_i,
    input  logic [WIDTH-1:0] dec_step_i,
    output logic [WIDTH-1:0] count_o,
    output logic             upd_o
);

    logic [WIDTH-1:0] nxt;
    logic             upd_comb;

    satcnt_next #(
        .W        (WIDTH),
        .SAT_EN   (SAT_EN),
        .HI_LIMIT (HI_LIMIT),
        .LO_LIMIT (LO_LIMIT)
    ) u_next (
        .cur_i      (count_o),
        .inc_req_i  (inc_req_i),
        .inc_step_i (inc_step_i),
        .dec_req_i  (dec_req_i),
        .dec_step_i (dec_step_i),
        .nxt_o      (nxt),
        .upd_o      (upd_comb)
    );

    satcnt_reg #(
        .W (WIDTH)
    ) u_reg (
        .clk    (clk),
        .rst    (rst),
        .load_i (upd_comb),
        .d_i    (nxt),
        .q_o    (count_o),
        .flag_o (upd_o)
    );

endmodule

// File: rtl/satcnt_chk.sv
module satcnt_chk #(
    parameter int          WIDTH    = 8,
    parameter bit          SAT_EN   = 1'b1,
    parameter int unsigned HI_LIMIT = 250
) (
    input logic             clk,
    input logic             rst,
    input logic             inc_req_i,
    input logic             dec_req_i,
    input logic [WIDTH-1:0] count_o,
    input logic             upd_o
);

    // R1: reset clears both outputs
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !upd_o));

    // R2: no request, no change and no flag
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!inc_req_i && !dec_req_i) |=> (!upd_o && $stable(count_o)));

    // R8: flag only follows a cycle with a request
    a_r8_flag_needs_request: assert property (@(posedge clk) disable iff (rst)
        upd_o |-> $past(inc_req_i || dec_req_i));

    // R8: flag low means the count did not move
    a_r8_quiet_is_stable: assert property (@(posedge clk) disable iff (rst)
        (!upd_o && !$past(rst)) |-> $stable(count_o));

    generate
        if (SAT_EN) begin : g_sat_checks
            // R6: never above the ceiling
            a_r6_below_ceiling: assert property (@(posedge clk) disable iff (rst)
                count_o <= WIDTH'(HI_LIMIT));

            // R6: increment alone never wraps downward
            a_r6_up_never_wraps: assert property (@(posedge clk) disable iff (rst)
                (inc_req_i && !dec_req_i) |=> (count_o >= $past(count_o)));
        end
    endgenerate

endmodule

bind satcnt_field satcnt_chk #(
    .WIDTH    (WIDTH),
    .SAT_EN   (SAT_EN),
    .HI_LIMIT (HI_LIMIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .inc_req_i (inc_req_i),
    .dec_req_i (dec_req_i),
    .count_o   (count_o),
    .upd_o     (upd_o)
);

// File: tb/sim_satcnt_field.sv
module sim_satcnt_field;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         inc_req = 1'b0, dec_req = 1'b0;
    logic [W-1:0] inc_step = '0, dec_step = '0;
    logic [W-1:0] count;
    logic         upd;
    logic         w_inc_req = 1'b0, w_dec_req = 1'b0;
    logic [W-1:0] w_inc_step = '0, w_dec_step = '0;
    logic [W-1:0] w_count;
    logic         w_upd;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    satcnt_field #(.WIDTH(W), .SAT_EN(1'b1), .HI_LIMIT(250), .LO_LIMIT(2)) u0 (
        .clk(clk), .rst(rst),
        .inc_req_i(inc_req), .inc_step_i(inc_step),
        .dec_req_i(dec_req), .dec_step_i(dec_step),
        .count_o(count), .upd_o(upd)
    );

    satcnt_field #(.WIDTH(W), .SAT_EN(1'b0), .HI_LIMIT(250), .LO_LIMIT(2)) u1 (
        .clk(clk), .rst(rst),
        .inc_req_i(w_inc_req), .inc_step_i(w_inc_step),
        .dec_req_i(w_dec_req), .dec_step_i(w_dec_step),
        .count_o(w_count), .upd_o(w_upd)
    );

    typedef struct packed {
        logic         inc;
        logic [W-1:0] istep;
        logic         dec;
        logic [W-1:0] dstep;
        logic [W-1:0] exp_cnt;
        logic         exp_upd;
        int           req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd0,   1'b0, 8'd0,   8'd0,   1'b0, 2},  // R2 idle
        '{1'b1, 8'd10,  1'b0, 8'd0,   8'd10,  1'b1, 3},  // R3 add
        '{1'b0, 8'd0,   1'b1, 8'd4,   8'd6,   1'b1, 4},  // R4 subtract
        '{1'b0, 8'd0,   1'b1, 8'd4,   8'd2,   1'b1, 7},  // R7 land on floor
        '{1'b0, 8'd0,   1'b1, 8'd1,   8'd2,   1'b0, 7},  // R7 below floor rejected
        '{1'b1, 8'd248, 1'b0, 8'd0,   8'd250, 1'b1, 6},  // R6 land on ceiling
        '{1'b1, 8'd1,   1'b0, 8'd0,   8'd250, 1'b0, 6},  // R6 above ceiling rejected
        '{1'b0, 8'd0,   1'b1, 8'd5,   8'd245, 1'b1, 4},  // R4
        '{1'b1, 8'd255, 1'b0, 8'd0,   8'd245, 1'b0, 6},  // R6 sum past 2^W, no wrap
        '{1'b1, 8'd5,   1'b1, 8'd3,   8'd247, 1'b1, 5},  // R5 both applied
        '{1'b1, 8'd10,  1'b1, 8'd3,   8'd244, 1'b1, 5},  // R5 inc rejected, dec applied
        '{1'b0, 8'd0,   1'b1, 8'd241, 8'd3,   1'b1, 4},  // R4
        '{1'b1, 8'd4,   1'b1, 8'd5,   8'd2,   1'b1, 5},  // R5 order matters
        '{1'b1, 8'd0,   1'b0, 8'd0,   8'd2,   1'b1, 9},  // R9 zero increment
        '{1'b0, 8'd0,   1'b1, 8'd0,   8'd2,   1'b1, 9},  // R9 zero decrement at floor
        '{1'b0, 8'd0,   1'b0, 8'd0,   8'd2,   1'b0, 8},  // R8 flag drops
        '{1'b0, 8'd0,   1'b1, 8'd255, 8'd2,   1'b0, 7},  // R7 borrow rejected
        '{1'b1, 8'd3,   1'b1, 8'd255, 8'd5,   1'b1, 5}   // R5 inc applied, dec rejected
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset count", int'(count), 0);
        check("R1 reset upd", int'(upd), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            inc_req  = VECS[i].inc;
            inc_step = VECS[i].istep;
            dec_req  = VECS[i].dec;
            dec_step = VECS[i].dstep;
            @(negedge clk);
            check($sformatf("R%0d vec%0d count", VECS[i].req, i), int'(count), int'(VECS[i].exp_cnt));
            check($sformatf("R%0d vec%0d upd", VECS[i].req, i), int'(upd), int'(VECS[i].exp_upd));
        end

        // R1: reset wins over a pending increment
        inc_req = 1'b1; inc_step = 8'd7; dec_req = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run count", int'(count), 0);
        check("R1 mid-run upd", int'(upd), 0);
        rst = 1'b0; inc_req = 1'b0;

        // R10: wrapping variant
        w_inc_req = 1'b1; w_inc_step = 8'd250;
        @(negedge clk);
        check("R10 wrap add 250", int'(w_count), 250);
        w_inc_step = 8'd10;
        @(negedge clk);
        check("R10 wrap add past top", int'(w_count), 4);
        check("R10 wrap upd", int'(w_upd), 1);
        w_inc_req = 1'b0; w_dec_req = 1'b1; w_dec_step = 8'd6;
        @(negedge clk);
        check("R10 wrap sub past zero", int'(w_count), 254);
        w_dec_req = 1'b0;
        @(negedge clk);
        check("R2 wrap idle", int'(w_count), 254);
        check("R2 wrap idle upd", int'(w_upd), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule